// File: doc/BRIEF.md
# Parallel-Port FIFO Service Interrupt Generator

This block produces the host interrupt of an enhanced parallel port that has a 16-byte data FIFO. It watches the port's control bits, the FIFO fill count, a programmed threshold code, a DMA terminal-count strobe and two peripheral status lines. When a qualifying event occurs, it emits a one-clock interrupt pulse.

The service mask bit acts as an inverted master gate for the DMA and FIFO-threshold sources. While the mask is 1, those sources are silent. Clearing the mask re-evaluates the threshold comparison at once. In the fill direction the comparison uses free space; in the drain direction it uses the stored byte count.

A DMA terminal count returns a one-clock request that tells the surrounding register logic to set the mask again, which stops further DMA. The fault and acknowledge lines are asynchronous. Each passes through a two-stage synchronizer before edge detection. The FIFO storage, the host bus decode and the DMA request logic all live outside the block.

Top module: `pport_intr_gen`

## Requirements
- R1: While `svc_mask` is 1, a terminal count and the FIFO thresholds cause no `irq` pulse and no `svc_set` pulse.
- R2: A `dma_tc` pulse sampled while `svc_mask`=0 and `dma_en`=1 produces a one-clock pulse on both `irq` and `svc_set` in the cycle after the sampling edge.
- R3: A `dma_tc` pulse while `dma_en`=0 produces no `svc_set`.
- R4: With `svc_mask`=0, `dma_en`=0 and `dir_rd`=0, the threshold condition is free bytes (16 − `fifo_cnt`) ≥ `thr_code`+1.
- R5: With `svc_mask`=0, `dma_en`=0 and `dir_rd`=1, the threshold condition is `fifo_cnt` ≥ `thr_code`+1. `thr_code`=0 means a threshold of 1 and `thr_code`=15 means 16.
- R6: The threshold interrupt is a single pulse one cycle after the condition becomes true. This covers both the count crossing the threshold and `svc_mask` falling while the condition already holds.
- R7: While `dma_en`=1, the threshold conditions raise no interrupt.
- R8: With `err_en_n`=0, a falling edge on `fault_n` gives a one-clock `irq` pulse three clock edges after it is first sampled. With `err_en_n`=1 it gives none.
- R9: Changing `err_en_n` from 1 to 0 while the synchronized `fault_n` is low gives one `irq` pulse on the next edge.
- R10: With `ack_en`=1, a rising edge on `ack_n` gives a one-clock `irq` pulse three edges after it is first sampled. A falling edge, or any edge while `ack_en`=0, gives none.
- R11: During and directly after reset, `irq` and `svc_set` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| svc_mask | input | 1 | Service mask bit, 1 masks DMA and threshold sources |
| dma_en | input | 1 | DMA mode enable |
| dir_rd | input | 1 | FIFO direction, 1 = peripheral to host |
| err_en_n | input | 1 | Active-low fault interrupt enable |
| ack_en | input | 1 | Acknowledge interrupt enable |
| fifo_cnt | input | 5 | Bytes stored in the FIFO (0 to 16) |
| thr_code | input | 4 | Threshold code, threshold = code + 1 |
| dma_tc | input | 1 | DMA terminal-count strobe |
| fault_n | input | 1 | Asynchronous peripheral fault line |
| ack_n | input | 1 | Asynchronous peripheral acknowledge line |
| irq | output | 1 | One-clock interrupt pulse |
| svc_set | output | 1 | One-clock request to set the service mask |

## Verification
The hardest situation to reach is a threshold condition that already holds at the instant the mask is cleared. A count that crosses the threshold triggers the same edge detector, so a test of the crossing case alone does not show that the mask-clear case works. The stimulus first holds the mask at 1 long enough for the stored condition to clear. It then sets the count, code and direction and drops the mask on the same edge. The expected pulse and its single-cycle width are checked for counts on both sides of each threshold boundary.

// File: rtl/pport_intr_gen.sv
module pport_intr_gen #(
  parameter int DEPTH = 16,
  parameter int THR_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_mask,
  input  logic             dma_en,
  input  logic             dir_rd,
  input  logic             err_en_n,
  input  logic             ack_en,
  input  logic [CNT_W-1:0] fifo_cnt,
  input  logic [THR_W-1:0] thr_code,
  input  logic             dma_tc,
  input  logic             fault_n,
  input  logic             ack_n,
  output logic             irq,
  output logic             svc_set
);

  logic [1:0] fault_sync, ack_sync;
  logic       ack_q;
  logic       thr_cond_q, err_cond_q;

  logic [CNT_W-1:0] free_cnt, thr_val;
  logic             thr_cond, err_cond, tc_hit, thr_rise, err_rise, ack_rise;

  assign free_cnt = CNT_W'(DEPTH) - fifo_cnt;
  assign thr_val  = CNT_W'(thr_code) + CNT_W'(1);

  assign thr_cond = !svc_mask && !dma_en &&
                    (dir_rd ? (fifo_cnt >= thr_val) : (free_cnt >= thr_val));
  assign tc_hit   = dma_tc && !svc_mask && dma_en;
  assign err_cond = !err_en_n && !fault_sync[1];

  assign thr_rise = thr_cond && !thr_cond_q;
  assign err_rise = err_cond && !err_cond_q;
  assign ack_rise = ack_en && ack_sync[1] && !ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_sync <= 2'b11;
      ack_sync   <= 2'b11;
      ack_q      <= 1'b1;
      thr_cond_q <= 1'b0;
      err_cond_q <= 1'b0;
      irq        <= 1'b0;
      svc_set    <= 1'b0;
    end else begin
      fault_sync <= {fault_sync[0], fault_n};
      ack_sync   <= {ack_sync[0], ack_n};
      ack_q      <= ack_sync[1];
      thr_cond_q <= thr_cond;
      err_cond_q <= err_cond;
      irq        <= tc_hit || thr_rise || err_rise || ack_rise;
      svc_set    <= tc_hit;
    end
  end

endmodule

module pport_intr_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic svc_mask,
  input logic dma_en,
  input logic err_en_n,
  input logic ack_en,
  input logic dma_tc,
  input logic irq,
  input logic svc_set
);

  AST_SET_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    svc_set |-> irq); // R2

  AST_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_set |-> $past(dma_tc && dma_en && !svc_mask)); // R2

  AST_SET_NEEDS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!dma_en) |-> !svc_set); // R3

  AST_MASK_BLOCKS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(svc_mask) |-> !svc_set); // R1

  AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(svc_mask && err_en_n && !ack_en) |-> !irq); // R1

endmodule

bind pport_intr_gen pport_intr_gen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .svc_mask(svc_mask), .dma_en(dma_en),
  .err_en_n(err_en_n), .ack_en(ack_en), .dma_tc(dma_tc),
  .irq(irq), .svc_set(svc_set)
);

// File: tb/test_pport_intr_gen.sv
module test_pport_intr_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       svc_mask = 1'b1, dma_en = 1'b0, dir_rd = 1'b0;
  logic       err_en_n = 1'b1, ack_en = 1'b0;
  logic [4:0] fifo_cnt = '0;
  logic [3:0] thr_code = '0;
  logic       dma_tc = 1'b0, fault_n = 1'b1, ack_n = 1'b1;
  logic       irq, svc_set;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pport_intr_gen i_pport_intr_gen (
    .clk(clk), .rst_n(rst_n), .svc_mask(svc_mask), .dma_en(dma_en),
    .dir_rd(dir_rd), .err_en_n(err_en_n), .ack_en(ack_en),
    .fifo_cnt(fifo_cnt), .thr_code(thr_code), .dma_tc(dma_tc),
    .fault_n(fault_n), .ack_n(ack_n), .irq(irq), .svc_set(svc_set)
  );

  // {svc_mask, dma_en, dir_rd, fifo_cnt[4:0], thr_code[3:0], expected irq}
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 5'd0,  4'd15, 1'b1},  // R4 free 16 >= 16
    {1'b0, 1'b0, 1'b0, 5'd1,  4'd15, 1'b0},  // R4 free 15 < 16
    {1'b0, 1'b0, 1'b0, 5'd8,  4'd7,  1'b1},  // R4 free 8 >= 8
    {1'b0, 1'b0, 1'b0, 5'd9,  4'd7,  1'b0},  // R4 free 7 < 8
    {1'b0, 1'b0, 1'b1, 5'd16, 4'd15, 1'b1},  // R5 16 >= 16
    {1'b0, 1'b0, 1'b1, 5'd15, 4'd15, 1'b0},  // R5 15 < 16
    {1'b0, 1'b0, 1'b1, 5'd1,  4'd0,  1'b1},  // R5 1 >= 1
    {1'b0, 1'b0, 1'b1, 5'd0,  4'd0,  1'b0},  // R5 0 < 1
    {1'b0, 1'b1, 1'b1, 5'd16, 4'd0,  1'b0},  // R7 dma mode
    {1'b0, 1'b1, 1'b0, 5'd0,  4'd0,  1'b0},  // R7 dma mode
    {1'b1, 1'b0, 1'b1, 5'd16, 4'd0,  1'b0}   // R1 masked
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_irq(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (irq) c++;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    step();
    chk(irq == 1'b0 && svc_set == 1'b0, "R11 in reset", {irq, svc_set}, 0);
    @(negedge clk) rst_n = 1'b1;
    step();
    chk(irq == 1'b0 && svc_set == 1'b0, "R11 after reset", {irq, svc_set}, 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      svc_mask = 1'b1; dma_en = 1'b0;
      step(); step();
      @(negedge clk);
      {svc_mask, dma_en, dir_rd, fifo_cnt, thr_code} = VEC[v][12:1];
      step();
      chk(irq == VEC[v][0], $sformatf("R6 vector %0d", v), irq, VEC[v][0]);
      step();
      chk(irq == 1'b0, $sformatf("R6 pulse width vector %0d", v), irq, 0);
    end

    @(negedge clk);
    svc_mask = 1'b1; dma_en = 1'b0; dir_rd = 1'b1; thr_code = 4'd3; fifo_cnt = 5'd3;
    step(); step();
    @(negedge clk) svc_mask = 1'b0;
    step();
    chk(irq == 1'b0, "R6 below threshold", irq, 0);
    @(negedge clk) fifo_cnt = 5'd4;
    step();
    chk(irq == 1'b1, "R6 crossing", irq, 1);
    @(negedge clk) fifo_cnt = 5'd5;
    step();
    chk(irq == 1'b0, "R6 stays above", irq, 0);

    @(negedge clk);
    svc_mask = 1'b0; dma_en = 1'b1; fifo_cnt = 5'd0; dma_tc = 1'b1;
    step();
    chk(irq == 1'b1 && svc_set == 1'b1, "R2 tc fires", {irq, svc_set}, 3);
    @(negedge clk) dma_tc = 1'b0;
    step();
    chk(irq == 1'b0 && svc_set == 1'b0, "R2 tc pulse ends", {irq, svc_set}, 0);

    @(negedge clk);
    svc_mask = 1'b1; dma_tc = 1'b1;
    step();
    chk(irq == 1'b0 && svc_set == 1'b0, "R1 tc masked", {irq, svc_set}, 0);
    @(negedge clk);
    svc_mask = 1'b0; dma_en = 1'b0;
    step();
    chk(irq == 1'b0 && svc_set == 1'b0, "R3 tc without dma", {irq, svc_set}, 0);
    @(negedge clk);
    dma_tc = 1'b0; svc_mask = 1'b1;
    step();

    @(negedge clk);
    err_en_n = 1'b0; fault_n = 1'b0;
    step(); chk(irq == 1'b0, "R8 edge 1", irq, 0);
    step(); chk(irq == 1'b0, "R8 edge 2", irq, 0);
    step(); chk(irq == 1'b1, "R8 edge 3", irq, 1);
    step(); chk(irq == 1'b0, "R8 pulse ends", irq, 0);
    @(negedge clk) fault_n = 1'b1;
    count_irq(4, c);
    @(negedge clk);
    err_en_n = 1'b1; fault_n = 1'b0;
    count_irq(5, c);
    chk(c == 0, "R8 disabled fault", c, 0);
    @(negedge clk) err_en_n = 1'b0;
    step(); chk(irq == 1'b1, "R9 enable while low", irq, 1);
    step(); chk(irq == 1'b0, "R9 pulse ends", irq, 0);
    @(negedge clk); err_en_n = 1'b1; fault_n = 1'b1;
    count_irq(4, c);

    @(negedge clk);
    ack_en = 1'b1; ack_n = 1'b0;
    count_irq(5, c);
    chk(c == 0, "R10 falling ignored", c, 0);
    @(negedge clk) ack_n = 1'b1;
    step(); chk(irq == 1'b0, "R10 edge 1", irq, 0);
    step(); chk(irq == 1'b0, "R10 edge 2", irq, 0);
    step(); chk(irq == 1'b1, "R10 edge 3", irq, 1);
    step(); chk(irq == 1'b0, "R10 pulse ends", irq, 0);
    @(negedge clk); ack_en = 1'b0; ack_n = 1'b0;
    count_irq(4, c);
    @(negedge clk) ack_n = 1'b1;
    count_irq(5, c);
    chk(c == 0, "R10 disabled rise", c, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule